// File: doc/BRIEF.md
# Fractional Serial Clock Divider

The block derives the bit-rate timing of a serial master from the peripheral clock. It emits a one-cycle toggle strobe at the end of every half period of the serial clock. Whatever drives the serial clock pin flips its level on each strobe. The length of a half period comes from a fixed-point setting in which 256 counts make one whole input-clock cycle of divisor. The serial clock rate is therefore the input rate divided by 2·(1 + setting/256). A setting of zero gives half the input rate.

The low eight bits of the setting are a fraction. They are added into a phase accumulator at every half period. When the accumulator wraps, that half period is one input cycle longer, so the long-run average rate is exact. The accumulator and the half-period counter clear whenever the enable is low or the setting changes. Every start therefore begins from a known phase, and the first strobe comes one whole half period after the start. Driver software writes multiples of 64, but the block accepts any value of the fraction.

Top module: `fdiv_sclk_gen`

## Requirements
- R1: While rst_ni is low, and on the first cycles after it rises with en_i low, tick_o is 0.
- R2: With a setting of 0 and en_i high, tick_o is 1 on every cycle after the first strobe, giving half the input clock rate.
- R3: A half period lasts 1 + setting[21:8] input cycles, plus one cycle when the accumulator wraps. Over 256 consecutive half periods from a start, the total is exactly 256 + setting cycles.
- R4: The accumulator starts from zero and adds setting[7:0] at the end of every half period. A wrap past 255 lengthens the half period that ends at that step. For setting 128, the half-period lengths alternate 1, 2, 1, 2.
- R5: When en_i is sampled high at edge E0 with the setting already stable, the first strobe is registered at edge E0 + 1 + setting[21:8].
- R6: A change of setting while enabled restarts the divider. If the new value is first sampled at edge C0, no strobe is produced from the old timing, and the first strobe is registered at edge C0 + 2 + new setting[21:8].
- R7: When en_i is sampled low, tick_o is 0 from the next cycle on and stays 0 while en_i is low.
- R8: The strobe is one cycle wide whenever setting[21:8] is nonzero.
- R9: Settings up to 2^21 are supported. For 2^21 the first half period is 8193 input cycles long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; low clears the divider |
| div_val_i | input | 22 | Divider setting, 8 fractional bits |
| tick_o | output | 1 | One-cycle strobe at each half-period end |

## Verification
tick_o is registered. A half period that ends on the counter match at edge k shows its strobe during the cycle after edge k. The first strobe after an enable is due 1 + setting[21:8] edges after the enable is sampled. After a change of setting it is due one edge later than that, because the change is first seen through the stored copy of the setting. The bench drives inputs on falling edges and numbers every rising edge from the start. It reads tick_o on the following falling edge and compares each edge number with the sum of half-period lengths that the requirements give.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;
  localparam int unsigned DIV_W_DEF  = 22;
  localparam int unsigned FRAC_W_DEF = 8;
endpackage

// File: rtl/fdiv_phase_acc.sv
module fdiv_phase_acc #(
  parameter int unsigned FRAC_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              step_i,
  input  logic [FRAC_W-1:0] frac_i,
  output logic              carry_o
);
  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W:0]   sum;

  assign sum     = {1'b0, acc_q} + {1'b0, frac_i};
  assign carry_o = sum[FRAC_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      acc_q <= '0;
    else if (clear_i) acc_q <= '0;
    else if (step_i)  acc_q <= sum[FRAC_W-1:0];
  end

  // a wrap must leave a smaller phase than before
  assert_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && carry_o && !clear_i) |=> (acc_q < $past(acc_q)));
endmodule

// File: rtl/fdiv_half_cnt.sv
module fdiv_half_cnt #(
  parameter int unsigned CNT_W = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             hit_o
);
  logic [CNT_W-1:0] cnt_q;

  assign hit_o = (cnt_q == limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (hit_o)   cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  assert_cnt_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i |-> (cnt_q <= limit_i));
endmodule

// File: rtl/fdiv_sclk_gen.sv
module fdiv_sclk_gen
  import fdiv_pkg::*;
#(
  parameter int unsigned DIV_W  = DIV_W_DEF,
  parameter int unsigned FRAC_W = FRAC_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_val_i,
  output logic             tick_o
);
  localparam int unsigned INT_W = DIV_W - FRAC_W;
  localparam int unsigned CNT_W = INT_W + 1;

  logic [DIV_W-1:0] div_q;
  logic             run_q, tick_q;
  logic             arm, clear, hit, carry, step;
  logic [INT_W-1:0] int_part;
  logic [CNT_W-1:0] limit;

  assign int_part = div_val_i[DIV_W-1:FRAC_W];
  // stable setting and enable; a change re-arms one cycle later
  assign arm      = en_i && (div_val_i == div_q);
  assign clear    = !(arm && run_q);
  assign step     = !clear && hit;
  assign limit    = {1'b0, int_part} + CNT_W'(carry);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      run_q  <= 1'b0;
      tick_q <= 1'b0;
    end else begin
      div_q  <= div_val_i;
      run_q  <= arm;
      tick_q <= step;
    end
  end

  assign tick_o = tick_q;

  generate
    if (FRAC_W > 0) begin : g_frac
      fdiv_phase_acc #(.FRAC_W(FRAC_W)) u_acc (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clear_i (clear),
        .step_i  (step),
        .frac_i  (div_val_i[FRAC_W-1:0]),
        .carry_o (carry)
      );
    end else begin : g_int
      assign carry = 1'b0;
    end
  endgenerate

  fdiv_half_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear),
    .limit_i (limit),
    .hit_o   (hit)
  );

  assert_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !tick_o);
  assert_restart_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && (div_val_i != div_q)) |=> !tick_o);
  assert_zero_rate_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && arm && (div_val_i == '0)) |=> tick_o);
  assert_one_wide_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && (int_part != '0)) |=> !tick_o);
endmodule

// File: tb/fdiv_sclk_gen_test.sv
module fdiv_sclk_gen_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic [21:0] div_val_i = '0;
  logic        tick_o;

  int checks = 0;
  int fails  = 0;
  int t_idx[4];
  int t_last;
  bit timed_out = 1'b0;

  fdiv_sclk_gen uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i),
    .div_val_i(div_val_i), .tick_o(tick_o)
  );

  always #10 clk_i = ~clk_i;

  // {setting, first strobe edge number, edge number of 256th strobe}
  localparam int NV = 8;
  localparam int VEC [NV][3] = '{
    '{0,    2, 257},  '{1,    2, 258},  '{64,   2, 321},  '{128,  2, 385},
    '{255,  2, 512},  '{256,  3, 513},  '{700,  4, 957},  '{1000, 5, 1257}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // number the rising edges from 1; record strobe edge numbers
  task automatic count_ticks(input int n, input int limit);
    int seen = 0;
    for (int i = 0; i < 4; i++) t_idx[i] = -1;
    t_last = -1;
    for (int e = 1; e <= limit && seen < n; e++) begin
      @(posedge clk_i);
      @(negedge clk_i);
      if (tick_o) begin
        if (seen < 4) t_idx[seen] = e;
        seen++;
        t_last = e;
      end
    end
  endtask

  task automatic restart_with(input logic [21:0] v);
    @(negedge clk_i);
    en_i = 1'b0;
    repeat (2) @(negedge clk_i);
    div_val_i = v;
    repeat (2) @(negedge clk_i);
    en_i = 1'b1;
  endtask

  initial begin
    #4000000;
    timed_out = 1'b1;
  end

  initial begin
    int zeros;
    // R1: reset state
    repeat (3) @(negedge clk_i);
    chk("R1 in reset", int'(tick_o), 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    chk("R1 after reset", int'(tick_o), 0);

    // R3/R5: table walk
    for (int v = 0; v < NV; v++) begin
      restart_with(22'(VEC[v][0]));
      count_ticks(256, 4000);
      chk($sformatf("R5 first strobe val %0d", VEC[v][0]), t_idx[0], VEC[v][1]);
      chk($sformatf("R3 256 half periods val %0d", VEC[v][0]), t_last, VEC[v][2]);
    end

    // R4: alternating lengths for setting 128
    restart_with(22'd128);
    count_ticks(4, 100);
    chk("R4 strobe 2", t_idx[1], 4);
    chk("R4 strobe 3", t_idx[2], 5);
    chk("R4 strobe 4", t_idx[3], 7);

    // R2: every cycle high with setting 0
    restart_with(22'd0);
    count_ticks(1, 10);
    zeros = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk_i);
      if (!tick_o) zeros++;
    end
    chk("R2 continuous strobe", zeros, 0);

    // R8: one-wide strobes for setting 512
    restart_with(22'd512);
    count_ticks(3, 100);
    chk("R8 spacing a", t_idx[1] - t_idx[0], 3);
    chk("R8 spacing b", t_idx[2] - t_idx[1], 3);

    // R6: change setting mid-run
    restart_with(22'd0);
    count_ticks(3, 10);
    @(negedge clk_i);
    div_val_i = 22'd512;
    count_ticks(1, 50);
    chk("R6 first strobe after change", t_idx[0], 5);

    // R7: enable low suppresses strobes
    restart_with(22'd0);
    count_ticks(2, 10);
    @(negedge clk_i);
    en_i = 1'b0;
    count_ticks(1, 30);
    chk("R7 no strobe while disabled", t_idx[0], -1);

    // R9: largest setting
    restart_with(22'h200000);
    count_ticks(1, 9000);
    chk("R9 first strobe at max", t_idx[0], 8194);

    if (timed_out) chk("watchdog", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    wait (timed_out);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule